// File: doc/BRIEF.md
# Three-Channel Match Timer with Synchronized Count Capture

This block holds three independent 32-bit up-counters that advance together on a shared tick-enable input. Every counter owns three match comparators, a preload word and a reload selector. When a counter advances while sitting on a comparator's value, that comparator's status bit is set. If the selector names that comparator, the counter jumps to its preload word instead of incrementing. Status bits combine with per-channel enable masks into one interrupt line per channel. Software clears status bits by writing ones.

All configuration goes through a simple word-addressed write port and a read port whose data is registered. Software reads channel 0's count safely through a capture register. A write to that register starts a request that passes through a short synchronizer chain. When the request leaves the chain, a stable copy of the count is taken and a valid flag is raised.

Top module: `tri_match_timer`

## Requirements
- R1: Word map with three channels n and three comparators k: comparator words at 3n+k (0..8); counts at 9+n; status at 12+n; interrupt mask at 15+n; preload at 18+n; reload selector at 21+n; status clear at 24+n; run bits at 27; capture at 28; capture valid at 29. Comparator words read back what was written.
- R2: Channel n's counter increments by one on each clock where `tick_en` is high and run bit n of word 27 is set. Otherwise it holds its value.
- R3: A reload selector value of 0 disables reload. Values 1, 2 and 3 select comparator 0, 1 and 2. On an advancing clock where the count equals the selected comparator, the next count is the preload word.
- R4: With comparator 0 at 0xFFFFFFFF, preload 0 and selector 1, the counter goes from 0xFFFFFFFF to 0 and then counts on.
- R5: On every advancing clock where the count equals comparator k, status bit k of that channel is set, whether or not comparator k drives reload.
- R6: `irq[n]` is high exactly when some status bit of channel n has its mask bit (same position, word 15+n) set.
- R7: Writing to word 24+n clears the status bits of channel n where the data has ones and leaves the other bits unchanged.
- R8: Writing data with bit 0 set to word 28 drops `cap_valid` at that clock edge. Two clock edges later, the current count of channel 0 is captured and `cap_valid` rises. Reads of word 28 return the captured value. A write to word 28 with bit 0 clear has no effect.
- R9: Read data appears on `rd_data` on the clock after `rd_en` is sampled. Unmapped words and the status-clear words read as zero.
- R10: After reset, all counts, status bits, masks, run bits, `irq` and `cap_valid` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared count tick enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt |
| cap_valid | output | 1 | Captured count is stable |

## Verification
The following are checked on every cycle:
- counters hold when not advancing;
- counters increment by exactly one when no reload is selected;
- a counter sitting on comparator 0 with selector 1 loads its preload;
- a match always leaves its status bit set;
- a capture request always drops `cap_valid`, which rises only the synchronizer depth after the last request.

The following are shown only by the bench's scenarios:
- the word map;
- exact count values after mixed reload and wrap sequences;
- the captured value itself;
- masked versus unmasked interrupts;
- selective status clearing;
- the ignored capture write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [3:0] {
    RK_NONE, RK_MATCH, RK_COUNT, RK_STATUS, RK_IE, RK_PRE,
    RK_CTL, RK_ICR, RK_CEN, RK_CAP, RK_CAPV
  } rkind_t;

  typedef struct packed {
    rkind_t     kind;
    logic [7:0] idx;
  } rsel_t;

  // Word map: comparators first, then six per-channel groups, then shared words.
  function automatic rsel_t reg_decode(input int unsigned a,
                                       input int unsigned nt,
                                       input int unsigned nc);
    rsel_t       r;
    int unsigned b;
    int unsigned g;
    r.kind = RK_NONE;
    r.idx  = '0;
    b      = nt * nc;
    if (a < b) begin
      r.kind = RK_MATCH;
      r.idx  = 8'(a);
    end else if (a < b + 6 * nt) begin
      g     = (a - b) / nt;
      r.idx = 8'((a - b) % nt);
      case (g)
        0:       r.kind = RK_COUNT;
        1:       r.kind = RK_STATUS;
        2:       r.kind = RK_IE;
        3:       r.kind = RK_PRE;
        4:       r.kind = RK_CTL;
        default: r.kind = RK_ICR;
      endcase
    end else if (a == b + 6 * nt) begin
      r.kind = RK_CEN;
    end else if (a == b + 6 * nt + 1) begin
      r.kind = RK_CAP;
    end else if (a == b + 6 * nt + 2) begin
      r.kind = RK_CAPV;
    end
    return r;
  endfunction

endpackage

// File: rtl/tmr_chan.sv
module tmr_chan #(
  parameter int DW = 32,
  parameter int NC = 3,
  parameter int SW = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [NC*DW-1:0] match_flat,
  input  logic [DW-1:0]    preload,
  input  logic [SW-1:0]    sel,
  input  logic [NC-1:0]    ie,
  input  logic             clr_we,
  input  logic [NC-1:0]    clr_bits,
  output logic [DW-1:0]    cnt,
  output logic [NC-1:0]    status,
  output logic             irq
);

  logic [NC-1:0] hit;
  logic          reload;
  logic [NC-1:0] st_d;

  for (genvar k = 0; k < NC; k++) begin : g_cmp
    assign hit[k] = adv && (cnt == match_flat[k*DW +: DW]);
  end

  always_comb begin
    reload = 1'b0;
    for (int k = 0; k < NC; k++) begin
      if (32'(sel) == k + 1 && hit[k]) reload = 1'b1;
    end
  end

  // a new match wins over a clear in the same clock
  always_comb st_d = (status & ~(clr_we ? clr_bits : '0)) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      status <= '0;
    end else begin
      if (adv) cnt <= reload ? preload : cnt + 1'b1;
      status <= st_d;
    end
  end

  assign irq = |(status & ie);

endmodule

// File: rtl/tmr_capture.sv
module tmr_capture #(
  parameter int DW     = 32,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic [DW-1:0] src,
  output logic [DW-1:0] cap,
  output logic          valid
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe  <= '0;
      cap   <= '0;
      valid <= 1'b0;
    end else begin
      // a fresh request restarts the chain so only the latest one lands
      pipe <= req ? STAGES'(1) : (pipe << 1);
      if (req) begin
        valid <= 1'b0;
      end else if (pipe[STAGES-1]) begin
        cap   <= src;
        valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmr_pkg::*;
#(
  parameter int NUM_TMR     = 3,
  parameter int NUM_CMP     = 3,
  parameter int DW          = 32,
  parameter int AW          = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick_en,
  input  logic               wr_en,
  input  logic [AW-1:0]      wr_addr,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  input  logic [AW-1:0]      rd_addr,
  output logic [DW-1:0]      rd_data,
  output logic [NUM_TMR-1:0] irq,
  output logic               cap_valid
);

  localparam int NM = NUM_TMR * NUM_CMP;
  localparam int SW = $clog2(NUM_CMP + 1);

  rsel_t                    wsel;
  rsel_t                    rsel;
  logic [NM*DW-1:0]         match_q;
  logic [NUM_TMR*DW-1:0]    pre_q;
  logic [NUM_TMR*DW-1:0]    cnt_w;
  logic [NUM_TMR*SW-1:0]    ctl_q;
  logic [NM-1:0]            ie_q;
  logic [NM-1:0]            st_w;
  logic [NUM_TMR-1:0]       cen_q;
  logic                     cap_req;
  logic [DW-1:0]            cap_w;
  logic [DW-1:0]            rdat;

  always_comb begin
    wsel = reg_decode(32'(wr_addr), NUM_TMR, NUM_CMP);
    rsel = reg_decode(32'(rd_addr), NUM_TMR, NUM_CMP);
  end

  // configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      match_q <= '0;
      pre_q   <= '0;
      ctl_q   <= '0;
      ie_q    <= '0;
      cen_q   <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NM; i++) begin
        if (wsel.kind == RK_MATCH && wsel.idx == 8'(i))
          match_q[i*DW +: DW] <= wr_data;
      end
      for (int t = 0; t < NUM_TMR; t++) begin
        if (wsel.idx == 8'(t)) begin
          case (wsel.kind)
            RK_IE:   ie_q[t*NUM_CMP +: NUM_CMP] <= wr_data[NUM_CMP-1:0];
            RK_PRE:  pre_q[t*DW +: DW]          <= wr_data;
            RK_CTL:  ctl_q[t*SW +: SW]          <= wr_data[SW-1:0];
            default: ;
          endcase
        end
      end
      if (wsel.kind == RK_CEN) cen_q <= wr_data[NUM_TMR-1:0];
    end
  end

  assign cap_req = wr_en && (wsel.kind == RK_CAP) && wr_data[0];

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_chan
    logic clr_we;
    assign clr_we = wr_en && (wsel.kind == RK_ICR) && (wsel.idx == 8'(t));

    tmr_chan #(.DW(DW), .NC(NUM_CMP), .SW(SW)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .adv        (tick_en && cen_q[t]),
      .match_flat (match_q[t*NUM_CMP*DW +: NUM_CMP*DW]),
      .preload    (pre_q[t*DW +: DW]),
      .sel        (ctl_q[t*SW +: SW]),
      .ie         (ie_q[t*NUM_CMP +: NUM_CMP]),
      .clr_we     (clr_we),
      .clr_bits   (wr_data[NUM_CMP-1:0]),
      .cnt        (cnt_w[t*DW +: DW]),
      .status     (st_w[t*NUM_CMP +: NUM_CMP]),
      .irq        (irq[t])
    );
  end

  tmr_capture #(.DW(DW), .STAGES(SYNC_STAGES)) u_cap (
    .clk   (clk),
    .rst   (rst),
    .req   (cap_req),
    .src   (cnt_w[DW-1:0]),
    .cap   (cap_w),
    .valid (cap_valid)
  );

  // read mux
  always_comb begin
    rdat = '0;
    case (rsel.kind)
      RK_MATCH: begin
        for (int i = 0; i < NM; i++)
          if (rsel.idx == 8'(i)) rdat = match_q[i*DW +: DW];
      end
      RK_COUNT, RK_STATUS, RK_IE, RK_PRE, RK_CTL: begin
        for (int t = 0; t < NUM_TMR; t++) begin
          if (rsel.idx == 8'(t)) begin
            case (rsel.kind)
              RK_COUNT:  rdat = cnt_w[t*DW +: DW];
              RK_STATUS: rdat[NUM_CMP-1:0] = st_w[t*NUM_CMP +: NUM_CMP];
              RK_IE:     rdat[NUM_CMP-1:0] = ie_q[t*NUM_CMP +: NUM_CMP];
              RK_PRE:    rdat = pre_q[t*DW +: DW];
              default:   rdat[SW-1:0] = ctl_q[t*SW +: SW];
            endcase
          end
        end
      end
      RK_CEN:  rdat[NUM_TMR-1:0] = cen_q;
      RK_CAP:  rdat = cap_w;
      RK_CAPV: rdat[0] = cap_valid;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rdat;
  end

endmodule

// File: rtl/tmr_check.sv
module tmr_check #(
  parameter int NUM_TMR     = 3,
  parameter int NUM_CMP     = 3,
  parameter int DW          = 32,
  parameter int SW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       tick_en,
  input logic [NUM_TMR-1:0]         cen,
  input logic [NUM_TMR*DW-1:0]      cnt,
  input logic [NUM_TMR*NUM_CMP-1:0] status,
  input logic [NUM_TMR*SW-1:0]      ctl,
  input logic [NUM_TMR*NUM_CMP*DW-1:0] match,
  input logic [NUM_TMR*DW-1:0]      pre,
  input logic                       cap_req,
  input logic                       cap_valid
);

  logic [7:0] since;

  always_ff @(posedge clk) begin
    if (rst)              since <= 8'hFF;
    else if (cap_req)     since <= 8'h00;
    else if (since != 8'hFF) since <= since + 8'h01;
  end

  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (rst) cap_req |=> !cap_valid); // R8
  AST_CAP_LATENCY: assert property (@(posedge clk) disable iff (rst) $rose(cap_valid) |-> since == 8'(SYNC_STAGES)); // R8

  for (genvar t = 0; t < NUM_TMR; t++) begin : g_t
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !(tick_en && cen[t]) |=> $stable(cnt[t*DW +: DW])); // R2
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst) (tick_en && cen[t] && ctl[t*SW +: SW] == '0) |=> cnt[t*DW +: DW] == $past(cnt[t*DW +: DW]) + 1'b1); // R2
    AST_RELOAD_CMP0: assert property (@(posedge clk) disable iff (rst) (tick_en && cen[t] && ctl[t*SW +: SW] == SW'(1) && cnt[t*DW +: DW] == match[t*NUM_CMP*DW +: DW]) |=> cnt[t*DW +: DW] == $past(pre[t*DW +: DW])); // R3
    for (genvar k = 0; k < NUM_CMP; k++) begin : g_k
      AST_MATCH_SETS: assert property (@(posedge clk) disable iff (rst) (tick_en && cen[t] && cnt[t*DW +: DW] == match[(t*NUM_CMP+k)*DW +: DW]) |=> status[t*NUM_CMP+k]); // R5
    end
  end

endmodule

bind tri_match_timer tmr_check #(
  .NUM_TMR(NUM_TMR), .NUM_CMP(NUM_CMP), .DW(DW), .SW(SW), .SYNC_STAGES(SYNC_STAGES)
) u_tmr_check (
  .clk       (clk),
  .rst       (rst),
  .tick_en   (tick_en),
  .cen       (cen_q),
  .cnt       (cnt_w),
  .status    (st_w),
  .ctl       (ctl_q),
  .match     (match_q),
  .pre       (pre_q),
  .cap_req   (cap_req),
  .cap_valid (cap_valid)
);

// File: tb/test_tri_match_timer.sv
module test_tri_match_timer;
  localparam int NT = 3, NC = 3, DW = 32, AW = 5;
  localparam int A_MATCH = 0, A_COUNT = 9, A_STATUS = 12, A_IE = 15, A_PRE = 18;
  localparam int A_CTL = 21, A_ICR = 24, A_CEN = 27, A_CAP = 28, A_CAPV = 29;

  logic clk = 1'b0, rst = 1'b1, tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NT-1:0] irq;
  logic          cap_valid;

  always #5 clk = ~clk;

  tri_match_timer i_tri_match_timer (
    .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .cap_valid(cap_valid)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  typedef struct { logic [DW-1:0] exp; string tag; } item_t;
  item_t sbq[$];
  logic pend = 1'b0;

  // reference model built from the requirements
  logic [DW-1:0] m_match [NT*NC];
  logic [DW-1:0] m_pre [NT];
  logic [DW-1:0] m_cnt [NT];
  logic [1:0]    m_sel [NT];
  logic [NC-1:0] m_st [NT];
  logic [NC-1:0] m_ie [NT];
  logic [NT-1:0] m_en = '0;
  logic [DW-1:0] m_cap = '0;

  task automatic chk(input logic [DW-1:0] act, input logic [DW-1:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) pend <= rd_en;

  // monitor: pops one expected item per completed read
  initial forever begin
    @(negedge clk);
    if (pend) begin
      item_t it;
      it = sbq.pop_front();
      chk(rd_data, it.exp, it.tag);
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < A_COUNT) m_match[a] = d;
    else if (a >= A_IE && a < A_PRE) m_ie[a-A_IE] = d[NC-1:0];
    else if (a >= A_PRE && a < A_CTL) m_pre[a-A_PRE] = d;
    else if (a >= A_CTL && a < A_ICR) m_sel[a-A_CTL] = d[1:0];
    else if (a >= A_ICR && a < A_CEN) m_st[a-A_ICR] &= ~d[NC-1:0];
    else if (a == A_CEN) m_en = d[NT-1:0];
    else if (a == A_CAP && d[0]) m_cap = m_cnt[0];
  endtask

  task automatic rd(input int a, input logic [DW-1:0] exp, input string tag);
    item_t it;
    it.exp = exp; it.tag = tag;
    @(negedge clk);
    sbq.push_back(it);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    for (int s = 0; s < n; s++) begin
      @(posedge clk);
      for (int t = 0; t < NT; t++) begin
        if (m_en[t]) begin
          logic [NC-1:0] hit;
          for (int k = 0; k < NC; k++) hit[k] = (m_cnt[t] == m_match[t*NC+k]);
          m_st[t] |= hit;
          if (m_sel[t] != 2'd0 && hit[m_sel[t]-1]) m_cnt[t] = m_pre[t];
          else m_cnt[t] = m_cnt[t] + 1;
        end
      end
    end
    @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input string tag);
    for (int t = 0; t < NT; t++)
      chk(DW'(irq[t]), DW'(|(m_st[t] & m_ie[t])), tag);
  endtask

  initial begin
    for (int i = 0; i < NT*NC; i++) m_match[i] = '0;
    for (int t = 0; t < NT; t++) begin
      m_pre[t] = '0; m_cnt[t] = '0; m_sel[t] = '0; m_st[t] = '0; m_ie[t] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk(DW'(irq), 0, "R10 irq after reset");
    chk(DW'(cap_valid), 0, "R10 cap_valid after reset");
    rd(A_COUNT, 0, "R10 count0 reset");
    rd(A_STATUS+2, 0, "R10 status2 reset");
    rd(A_CEN, 0, "R10 run bits reset");
    rd(A_CAPV, 0, "R10 capture valid word reset");

    // R1 comparator word map
    for (int i = 0; i < NT*NC; i++) wr(A_MATCH+i, 32'hA000_0000 + 32'(i) * 32'h111);
    for (int i = 0; i < NT*NC; i++) rd(A_MATCH+i, m_match[i], "R1 comparator readback");

    // R9 unmapped and clear words read zero
    rd(31, 0, "R9 unmapped word");
    rd(A_ICR+1, 0, "R9 clear word reads zero");

    // R2 gating by run bits and tick
    tick(5);
    rd(A_COUNT+1, 0, "R2 no run bit no count");
    wr(A_CEN, 32'b010);
    tick(7);
    rd(A_COUNT+1, m_cnt[1], "R2 count1 after 7 ticks");
    rd(A_COUNT+0, 0, "R2 count0 stopped");
    repeat (4) @(negedge clk);
    rd(A_COUNT+1, m_cnt[1], "R2 holds without tick");
    wr(A_CEN, 0);
    tick(4);
    rd(A_COUNT+1, m_cnt[1], "R2 holds without run bit");

    // R3 reload from comparator 0 on channel 2
    wr(A_MATCH+6, 5); wr(A_PRE+2, 2); wr(A_CTL+2, 1); wr(A_CEN, 32'b100);
    tick(10);
    rd(A_COUNT+2, 32'd2, "R3 reload via comparator 0");
    rd(A_STATUS+2, 32'b001, "R5 status2 comparator 0");

    // R3 reload via comparator 2, R5 status from non-reload comparator
    wr(A_MATCH+4, 5); wr(A_MATCH+5, 9); wr(A_PRE+1, 4); wr(A_CTL+1, 3); wr(A_CEN, 32'b010);
    tick(6);
    rd(A_COUNT+1, 32'd7, "R3 reload via comparator 2");
    rd(A_STATUS+1, 32'b110, "R5 status1 bits 1 and 2");

    // R6 masking
    chk_irq("R6 all masked");
    wr(A_IE+1, 32'b010);
    chk(DW'(irq[1]), 1, "R6 irq1 unmasked");
    wr(A_IE+1, 32'b001);
    chk(DW'(irq[1]), 0, "R6 irq1 masked bit not set");

    // R7 selective clear
    wr(A_ICR+1, 32'b100);
    rd(A_STATUS+1, 32'b010, "R7 clear only bit 2");
    wr(A_IE+1, 32'b010);
    chk(DW'(irq[1]), 1, "R7 remaining bit still raises irq");
    wr(A_ICR+1, 32'b010);
    chk(DW'(irq[1]), 0, "R7 irq drops after clear");
    rd(A_STATUS+1, 0, "R7 status1 cleared");

    // R4 wrap through all ones on channel 0
    wr(A_PRE+0, 32'hFFFF_FFFD); wr(A_MATCH+1, 0); wr(A_CTL+0, 2); wr(A_CEN, 32'b001);
    tick(1);
    rd(A_COUNT+0, 32'hFFFF_FFFD, "R3 reload via comparator 1");
    wr(A_PRE+0, 0); wr(A_MATCH+0, 32'hFFFF_FFFF); wr(A_CTL+0, 1);
    tick(3);
    rd(A_COUNT+0, 0, "R4 wrap to zero");
    tick(2);
    rd(A_COUNT+0, 32'd2, "R4 counts on after wrap");
    rd(A_STATUS+0, 32'b011, "R5 status0 after wrap");
    chk_irq("R6 channel 0 masked");

    // R8 capture request latency and value
    wr(A_CAP, 1);
    chk(DW'(cap_valid), 0, "R8 valid dropped on request");
    @(negedge clk);
    chk(DW'(cap_valid), 0, "R8 valid low one edge later");
    @(negedge clk);
    chk(DW'(cap_valid), 1, "R8 valid after two edges");
    rd(A_CAP, m_cap, "R8 captured count0");
    rd(A_CAPV, 1, "R8 valid word");
    wr(A_CAP, 32'hFFFF_FFFE);
    repeat (3) @(negedge clk);
    chk(DW'(cap_valid), 1, "R8 bit0 clear ignored");
    tick(3);
    rd(A_CAP, 32'd2, "R8 capture holds while counting");
    wr(A_CAP, 1);
    repeat (3) @(negedge clk);
    rd(A_CAP, 32'd5, "R8 second capture");

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1-suite act=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule